// File: doc/BRIEF.md
# Segment Eviction Writeback Walker

When an entry of the segment residency map is chosen as a victim, some lines of that segment may still sit in the DRAM cache, and some of them may be dirty. This block is the engine that makes the victim entry safe to reuse. It takes one victim at a time: the segment base address, a 64-bit vector with one residency bit per 64-byte line, and a single dirty flag for the whole segment. The map keeps no dirty state per line, so the walker has to ask the in-DRAM tag store about every resident line.

For a clean segment the walker returns a completion pulse straight away and touches nothing. For a dirty segment it goes through the set residency bits from the lowest index to the highest. For each one it sends a probe to the tag store and waits for the answer. The probe also removes the line from the cache. A line the tag store reports as present and dirty is sent to main memory as a writeback. A line reported absent (already replaced) or clean costs nothing more. The completion pulse comes only after the last writeback has been accepted. The map may then hand the entry to a new segment.

All data interfaces use valid/ready. A request (victim, probe, writeback) transfers in a cycle where valid and ready are both high. Once the walker raises a probe or a writeback valid, it holds that valid and its address unchanged until ready is seen. Any number of stall cycles is allowed. The victim port accepts only while the walker is idle. A victim offered while busy simply waits. The probe response port is ready only while a probe answer is awaited.

Top module: `seg_wb_walker`

## Requirements
- R1: After reset the walker is idle. `vic_ready` is 1, and `tq_valid`, `tr_ready`, `wb_valid` and `done` are 0.
- R2: A victim accepted with `vic_dirty`=0 produces `done` in the cycle right after acceptance. No probe and no writeback are issued, whatever its residency vector holds.
- R3: For a victim accepted with `vic_dirty`=1, exactly one probe is issued for each set bit of `vic_resident`, and the probes go in ascending bit index order. A dirty victim with an all-zero vector issues no probe and still gives `done`.
- R4: The probe address for residency bit i is `vic_base` + i*64. Bit 0 of `vic_resident` is the line at the segment base.
- R5: At most one probe is outstanding. After a probe transfers, `tq_valid` stays low until its response has been taken (`tr_valid` and `tr_ready` both high).
- R6: A writeback is issued only when the response has `tr_present`=1 and `tr_dirty`=1. Its address equals that probe's address. A response with either flag at 0 produces no writeback.
- R7: While `tq_valid` or `wb_valid` is high without its ready, that valid and its address stay unchanged in the next cycle.
- R8: `done` is a one-cycle pulse. There is exactly one pulse per accepted victim, and it comes after the last writeback of that victim has been accepted.
- R9: `vic_ready` is 0 from the cycle after acceptance until the `done` pulse has ended. A victim held valid during that time is accepted only after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vic_valid | input | 1 | Victim segment offered |
| vic_ready | output | 1 | Walker idle, victim can transfer |
| vic_base | input | ADDR_W | Segment base byte address |
| vic_resident | input | LINES | Residency bit per line, bit i = line i |
| vic_dirty | input | 1 | Segment has ever been written |
| tq_valid | output | 1 | Tag probe (lookup and invalidate) request |
| tq_ready | input | 1 | Tag store accepts probe |
| tq_addr | output | ADDR_W | Line address probed |
| tr_valid | input | 1 | Probe response valid |
| tr_ready | output | 1 | Walker waiting for a probe response |
| tr_present | input | 1 | Probed line was in the cache |
| tr_dirty | input | 1 | Probed line was modified |
| wb_valid | output | 1 | Writeback request to main memory |
| wb_ready | input | 1 | Main memory accepts writeback |
| wb_addr | output | ADDR_W | Line address written back |
| done | output | 1 | One-cycle pulse: victim entry free |

## Verification
Two things can fall in the same cycle: the completion pulse for one victim, and a second victim that is already waiting at the input. The bench provokes this by keeping `vic_valid` high with the next segment's fields as soon as the first one is accepted. It judges the result by checking three points. `vic_ready` must stay low through the pulse. The second acceptance must come after the first pulse. The probe stream must show the first segment's lines complete before any of the second's. Stalls on the probe and writeback ports, and a range of response delays, check that requests stay stable and that only one probe is ever outstanding.

// File: rtl/seg_wb_pkg.sv
package seg_wb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_REQ,
    ST_RSP,
    ST_WB,
    ST_FIN
  } walk_state_t;
endpackage

// File: rtl/seg_wb_pick.sv
module seg_wb_pick #(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx
);
  // isolate the lowest set bit, then encode its position
  assign grant = vec & (~vec + N'(1));
  assign found = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/seg_wb_ctrl.sv
module seg_wb_ctrl
  import seg_wb_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 64,
  localparam int IW = $clog2(LINES),
  localparam int LS = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vic_valid,
  output logic              vic_ready,
  input  logic [ADDR_W-1:0] vic_base,
  input  logic [LINES-1:0]  vic_resident,
  input  logic              vic_dirty,
  output logic              tq_valid,
  input  logic              tq_ready,
  output logic [ADDR_W-1:0] tq_addr,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic              tr_present,
  input  logic              tr_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              done,
  output logic [LINES-1:0]  pend,
  input  logic              pick_found,
  input  logic [LINES-1:0]  pick_grant,
  input  logic [IW-1:0]     pick_idx
);
  walk_state_t       state;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] line_off;

  assign line_off = {{(ADDR_W-IW){1'b0}}, pick_idx} << LS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= '0;
      base_q <= '0;
      line_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (vic_valid) begin
          base_q <= vic_base;
          pend   <= vic_dirty ? vic_resident : '0;
          state  <= vic_dirty ? ST_SEL : ST_FIN;
        end
        ST_SEL: if (pick_found) begin
          line_q <= base_q + line_off;
          pend   <= pend & ~pick_grant;
          state  <= ST_REQ;
        end else begin
          state <= ST_FIN;
        end
        ST_REQ: if (tq_ready) state <= ST_RSP;
        ST_RSP: if (tr_valid) state <= (tr_present && tr_dirty) ? ST_WB : ST_SEL;
        ST_WB:  if (wb_ready) state <= ST_SEL;
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign vic_ready = (state == ST_IDLE);
  assign tq_valid  = (state == ST_REQ);
  assign tr_ready  = (state == ST_RSP);
  assign wb_valid  = (state == ST_WB);
  assign done      = (state == ST_FIN);
  assign tq_addr   = line_q;
  assign wb_addr   = line_q;

  assert_clean_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && vic_ready && !vic_dirty |=> done);
  assert_pick_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEL) && (pend != '0) |-> ($countones(pick_grant) == 1) && ((pick_grant & pend) == pick_grant));
  assert_single_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tq_valid && tq_ready |=> !tq_valid);
  assert_wb_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(tr_valid && tr_ready && tr_present && tr_dirty));
  assert_tq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tq_valid && !tq_ready |=> tq_valid && $stable(tq_addr));
  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid && vic_ready |=> !vic_ready);
endmodule

// File: rtl/seg_wb_walker.sv
module seg_wb_walker #(
  parameter int ADDR_W     = 48,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 64,
  localparam int IW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vic_valid,
  output logic              vic_ready,
  input  logic [ADDR_W-1:0] vic_base,
  input  logic [LINES-1:0]  vic_resident,
  input  logic              vic_dirty,
  output logic              tq_valid,
  input  logic              tq_ready,
  output logic [ADDR_W-1:0] tq_addr,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic              tr_present,
  input  logic              tr_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              done
);
  logic [LINES-1:0] pend;
  logic [LINES-1:0] grant;
  logic             found;
  logic [IW-1:0]    idx;

  seg_wb_pick #(.N(LINES)) u_pick (
    .vec   (pend),
    .found (found),
    .grant (grant),
    .idx   (idx)
  );

  seg_wb_ctrl #(
    .ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .vic_valid    (vic_valid),
    .vic_ready    (vic_ready),
    .vic_base     (vic_base),
    .vic_resident (vic_resident),
    .vic_dirty    (vic_dirty),
    .tq_valid     (tq_valid),
    .tq_ready     (tq_ready),
    .tq_addr      (tq_addr),
    .tr_valid     (tr_valid),
    .tr_ready     (tr_ready),
    .tr_present   (tr_present),
    .tr_dirty     (tr_dirty),
    .wb_valid     (wb_valid),
    .wb_ready     (wb_ready),
    .wb_addr      (wb_addr),
    .done         (done),
    .pend         (pend),
    .pick_found   (found),
    .pick_grant   (grant),
    .pick_idx     (idx)
  );
endmodule

// File: tb/seg_wb_walker_tb.sv
module seg_wb_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          vic_valid = 0, vic_ready, vic_dirty = 0;
  logic [AW-1:0] vic_base = '0;
  logic [63:0]   vic_resident = '0;
  logic          tq_valid, tq_ready = 1;
  logic [AW-1:0] tq_addr;
  logic          tr_valid = 0, tr_ready, tr_present = 0, tr_dirty = 0;
  logic          wb_valid, wb_ready = 1;
  logic [AW-1:0] wb_addr;
  logic          done;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_wb_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_base(vic_base),
    .vic_resident(vic_resident), .vic_dirty(vic_dirty),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_addr(tq_addr),
    .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_present(tr_present), .tr_dirty(tr_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .done(done)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [63:0] m_pres = '0, m_dirty = '0;
  bit bp_on = 0;
  int bp_cnt = 0;
  int rsp_lat = 0;

  logic [AW-1:0] lk_log [256];
  logic [AW-1:0] wb_log [256];
  logic [AW-1:0] exp_lk [256];
  logic [AW-1:0] exp_wb [256];
  int lk_n, wb_n, done_n, acc_n, exp_lk_n, exp_wb_n;
  int acc_log [4];
  int done_log [4];
  int last_wb_cyc;
  bit outstanding, r5_err, hold_err, ready_err, busy;
  bit prev_tq_stall, prev_wb_stall;
  logic [AW-1:0] prev_tq_addr, prev_wb_addr;

  always @(posedge clk) cyc <= cyc + 1;

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    tq_ready = bp_on ? (bp_cnt % 3 == 0) : 1'b1;
    wb_ready = bp_on ? (bp_cnt % 4 == 1) : 1'b1;
  end

  // tag store responder
  initial begin
    forever begin
      @(negedge clk);
      if (tq_valid && tq_ready) begin
        int i;
        i = int'(tq_addr[11:6]);
        @(posedge clk);
        repeat (rsp_lat) @(posedge clk);
        #1;
        tr_valid = 1; tr_present = m_pres[i]; tr_dirty = m_dirty[i];
        forever begin
          @(negedge clk);
          if (tr_ready) break;
        end
        @(posedge clk);
        #1 tr_valid = 0;
      end
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && vic_ready) ready_err = 1;
      if (vic_valid && vic_ready) begin
        if (acc_n < 4) acc_log[acc_n] = cyc;
        acc_n++; busy = 1;
      end
      if (tr_valid && tr_ready) outstanding = 0;
      if (tq_valid && outstanding) r5_err = 1;
      if (prev_tq_stall && !(tq_valid && tq_addr == prev_tq_addr)) hold_err = 1;
      if (prev_wb_stall && !(wb_valid && wb_addr == prev_wb_addr)) hold_err = 1;
      prev_tq_stall = tq_valid && !tq_ready; prev_tq_addr = tq_addr;
      prev_wb_stall = wb_valid && !wb_ready; prev_wb_addr = wb_addr;
      if (tq_valid && tq_ready) begin
        if (lk_n < 256) lk_log[lk_n] = tq_addr;
        lk_n++; outstanding = 1;
      end
      if (wb_valid && wb_ready) begin
        if (wb_n < 256) wb_log[wb_n] = wb_addr;
        wb_n++; last_wb_cyc = cyc;
      end
      if (done) begin
        if (done_n < 4) done_log[done_n] = cyc;
        done_n++; busy = 0;
      end
    end
  end

  task automatic check(bit ok, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic clear_logs();
    lk_n = 0; wb_n = 0; done_n = 0; acc_n = 0; exp_lk_n = 0; exp_wb_n = 0;
    last_wb_cyc = -1; r5_err = 0; hold_err = 0; ready_err = 0;
  endtask

  task automatic add_expect(logic [AW-1:0] base, logic [63:0] res, bit sdirty);
    if (sdirty) begin
      for (int i = 0; i < 64; i++) begin
        if (res[i]) begin
          exp_lk[exp_lk_n] = base + AW'(i) * 64;
          exp_lk_n++;
          if (m_pres[i] && m_dirty[i]) begin
            exp_wb[exp_wb_n] = base + AW'(i) * 64;
            exp_wb_n++;
          end
        end
      end
    end
  endtask

  task automatic offer(logic [AW-1:0] base, logic [63:0] res, bit sdirty);
    @(posedge clk); #1;
    vic_valid = 1; vic_base = base; vic_resident = res; vic_dirty = sdirty;
    forever begin
      @(negedge clk);
      if (vic_ready) break;
    end
    @(posedge clk); #1 vic_valid = 0;
  endtask

  task automatic wait_done(int n);
    int t = 0;
    while (done_n < n && t < 5000) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic compare_streams(string tag);
    bit ok = (lk_n == exp_lk_n);
    check(ok, {"R3 probe count ", tag}, lk_n, exp_lk_n);
    ok = 1;
    for (int i = 0; i < exp_lk_n && i < lk_n; i++)
      if (lk_log[i] !== exp_lk[i]) begin
        if (ok) check(0, {"R4 probe address/order ", tag}, lk_log[i], exp_lk[i]);
        ok = 0;
      end
    if (ok) check(1, "R4", 0, 0);
    check(wb_n == exp_wb_n, {"R6 writeback count ", tag}, wb_n, exp_wb_n);
    ok = 1;
    for (int i = 0; i < exp_wb_n && i < wb_n; i++)
      if (wb_log[i] !== exp_wb[i]) begin
        if (ok) check(0, {"R6 writeback address ", tag}, wb_log[i], exp_wb[i]);
        ok = 0;
      end
    if (ok) check(1, "R6", 0, 0);
    check(!r5_err, {"R5 probe issued while outstanding ", tag}, r5_err, 0);
    check(!hold_err, {"R7 request changed under stall ", tag}, hold_err, 0);
  endtask

  task automatic run_case(string tag, logic [AW-1:0] base, logic [63:0] res, bit sdirty,
                          logic [63:0] pres, logic [63:0] drt, bit bp, int lat);
    clear_logs();
    m_pres = pres; m_dirty = drt; bp_on = bp; rsp_lat = lat;
    add_expect(base, res, sdirty);
    offer(base, res, sdirty);
    wait_done(1);
    @(negedge clk);
    check(done == 0, {"R8 done is single pulse ", tag}, done, 0);
    check(done_n == 1, {"R8 one done per victim ", tag}, done_n, 1);
    if (wb_n > 0)
      check(done_log[0] > last_wb_cyc, {"R8 done after last writeback ", tag}, done_log[0], last_wb_cyc + 1);
    if (!sdirty)
      check(done_log[0] == acc_log[0] + 1, {"R2 clean done latency ", tag}, done_log[0] - acc_log[0], 1);
    compare_streams(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vic_ready == 1 && tq_valid == 0 && tr_ready == 0 && wb_valid == 0 && done == 0,
          "R1 reset outputs", {vic_ready, tq_valid, tr_ready, wb_valid, done}, 5'b10000);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(vic_ready == 1 && done == 0, "R1 idle after reset", {vic_ready, done}, 2'b10);
  endtask

  task automatic t_back_to_back();
    logic [AW-1:0] b1 = 48'h0000_1234_5000;
    logic [AW-1:0] b2 = 48'h0000_0ABC_D000;
    logic [63:0]   r1 = 64'h0000_0000_0000_00F1;
    logic [63:0]   r2 = 64'h8000_0000_0000_0006;
    clear_logs();
    m_pres = '1; m_dirty = 64'hAAAA_AAAA_AAAA_AAAA; bp_on = 1; rsp_lat = 1;
    add_expect(b1, r1, 1);
    add_expect(b2, r2, 1);
    @(posedge clk); #1;
    vic_valid = 1; vic_base = b1; vic_resident = r1; vic_dirty = 1;
    forever begin @(negedge clk); if (vic_ready) break; end
    @(posedge clk); #1;
    vic_base = b2; vic_resident = r2; vic_dirty = 1;
    while (acc_n < 2) @(negedge clk);
    @(posedge clk); #1 vic_valid = 0;
    wait_done(2);
    check(acc_n == 2 && done_n == 2, "R9 both victims completed", done_n, 2);
    check(acc_log[1] > done_log[0], "R9 second accepted after first done", acc_log[1], done_log[0] + 1);
    check(!ready_err, "R9 vic_ready low while busy", ready_err, 0);
    compare_streams("back-to-back");
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R2: clean segment with many resident lines
    run_case("clean", 48'h0000_4000_0000, 64'hFFFF_0000_1234_FFFF, 0, '1, '1, 0, 0);
    // R3 R4 R6 R8: mixed present/dirty, no stalls
    run_case("mixed", 48'h0000_0010_3000, 64'h0123_4567_89AB_CDEF, 1,
             64'hF0F0_F0F0_FFFF_0000, 64'hFF00_FF00_F0F0_F0F0, 0, 0);
    // R5 R7: full segment all dirty, with stalls and slow responses
    run_case("full-stall", 48'h0000_7FFF_F000, '1, 1, '1, '1, 1, 3);
    // R3: dirty segment with empty vector
    run_case("empty", 48'h0000_0000_8000, '0, 1, '1, '1, 0, 0);
    // R6: end lines absent, nothing written back
    run_case("absent", 48'h0000_0002_0000, 64'h8000_0000_0000_0001, 1, '0, '1, 0, 2);
    // R6: present but clean lines
    run_case("clean-lines", 48'h0000_0002_1000, 64'h8000_0000_0000_0001, 1, '1, '0, 1, 0);
    // R9: second victim waiting across done
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule